// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is an up counter built from identical four-bit slices. Each slice has a synchronous parallel load, an active-low clear, and two count enables. A slice advances only when both enables are high. Only the second enable, called the carry enable, gates the slice's carry output. That carry output goes high when the slice holds all ones and its carry enable is high.

The top module chains a parameterised number of slices. Load, clear, data and the first enable go to every slice. The carry enable of each slice comes from the carry output of the slice below it. The chain therefore counts as one wide binary counter with no gating outside the slices.

A build parameter selects the clear behaviour:
- Synchronous clear zeroes the count at the next rising edge. A user can then decode a terminal value onto the clear input to get a modulo-N count.
- Asynchronous clear zeroes the count as soon as the clear input falls.

Top module: `cnt_chain`

## Requirements
- R1: With clear and load inactive and the two enables not both high, the count does not change at the clock edge. Every bit of the count changes only at a rising clock edge.
- R2: With clear inactive (high), load_n low makes the count equal `din` after the next rising edge, whatever the levels of `en_p` and `en_t`.
- R3: Clear takes priority over load and counting.
  - In the synchronous build (ASYNC_CLR = 0), `clr_n` low zeroes the count at the next rising edge and not before.
  - In the asynchronous build (ASYNC_CLR = 1), `clr_n` low zeroes the count at once, without a clock edge.
- R4: With clear and load inactive, the count rises by one at a rising edge only when `en_p` and `en_t` are both high. All ones wraps to zero.
- R5: `carry_out` is high exactly when `en_t` is high and every bit of the count is one. `en_p` has no effect on it.
- R6: Across slice boundaries the chain behaves as one binary counter of NUM_SLICES*SLICE_W bits. Slice k advances only when every lower slice holds all ones, for example 0x0F to 0x10 and 0xFF to 0x00.
- R7: In the synchronous build, feeding a decode of count == N-1 into `clr_n` with both enables high yields a repeating count 0, 1, ..., N-1, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, synchronous or asynchronous per ASYNC_CLR |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Count enable, does not affect the carry output |
| en_t | input | 1 | Count enable that also gates the carry output |
| din | input | NUM_SLICES*SLICE_W | Parallel load data |
| count | output | NUM_SLICES*SLICE_W | Current count |
| carry_out | output | 1 | High when `en_t` is high and the count is all ones |

## Verification
The bench checks the priority order:
- It asserts load with both enables low; a design that let the enables gate the load would hold its old value.
- It asserts clear together with load; a design with the wrong priority would load instead of clearing.

At all ones, the bench drops `en_t` and, separately, `en_p`. A carry decode that used `en_p` or ignored `en_t` shows the wrong carry level.

The bench crosses slice boundaries at 0x0F, 0x7F and 0xFF, which catches a chain that passes carry incorrectly. It times the clear on both builds, which exposes a synchronous clear that acts early or an asynchronous clear that waits for the clock.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    // Operation chosen for a slice at the coming clock edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);

    // Clear beats load, load beats counting, otherwise hold.
    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_p && en_t) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH     = 4,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             rco
);

    localparam logic [WIDTH-1:0] TERMINAL = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } slice_state_t;

    cnt_op_e      op;
    slice_state_t st_d;
    slice_state_t st_q;

    cnt_op_decode u_dec (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_CLEAR: st_d.cnt = '0;
            OP_LOAD:  st_d.cnt = din;
            OP_COUNT: st_d.cnt = st_q.cnt + ONE;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    generate
        if (ASYNC_CLR) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end
    endgenerate

    assign q   = st_q.cnt;
    assign rco = en_t && (st_q.cnt == TERMINAL);

    // R3: a clear seen at an edge leaves the slice at zero.
    p_clear_zero_r3: assert property (@(posedge clk)
        !clr_n |=> (q == '0));

    // R2: load takes the data regardless of the enables.
    p_load_data_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(din)));

    // R4: both enables high advances the slice by one, wrapping.
    p_count_step_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t) |=> (q == $past(q) + ONE));

    // R1: no active control keeps the slice value.
    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_p && en_t)) |=> $stable(q));

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
    parameter int unsigned NUM_SLICES = 2,
    parameter int unsigned SLICE_W    = 4,
    parameter bit          ASYNC_CLR  = 1'b0
) (
    input  logic                             clk,
    input  logic                             clr_n,
    input  logic                             load_n,
    input  logic                             en_p,
    input  logic                             en_t,
    input  logic [NUM_SLICES*SLICE_W-1:0]    din,
    output logic [NUM_SLICES*SLICE_W-1:0]    count,
    output logic                             carry_out
);

    localparam int unsigned TOTAL_W = NUM_SLICES * SLICE_W;
    localparam logic [TOTAL_W-1:0] ONE_W = {{(TOTAL_W-1){1'b0}}, 1'b1};

    // t_chain[k] is the carry enable of slice k; the last entry leaves the chain.
    logic [NUM_SLICES:0] t_chain;

    assign t_chain[0] = en_t;

    generate
        for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
            cnt_slice #(
                .WIDTH     (SLICE_W),
                .ASYNC_CLR (ASYNC_CLR)
            ) u_slice (
                .clk    (clk),
                .clr_n  (clr_n),
                .load_n (load_n),
                .en_p   (en_p),
                .en_t   (t_chain[g]),
                .din    (din[g*SLICE_W +: SLICE_W]),
                .q      (count[g*SLICE_W +: SLICE_W]),
                .rco    (t_chain[g+1])
            );
        end
    endgenerate

    assign carry_out = t_chain[NUM_SLICES];

    // R5: the chain carry implies full ones and the carry enable.
    p_carry_full_r5: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (en_t && (&count)));

    // R6: the whole chain steps as one wide binary counter.
    p_chain_step_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t) |=> (count == $past(count) + ONE_W));

endmodule

// File: tb/test_cnt_chain.sv
`timescale 1ns/1ps
module test_cnt_chain;

    localparam int unsigned W = 8;
    localparam int unsigned NVEC = 16;
    localparam int unsigned MOD_N = 10;

    typedef struct packed {
        logic         clr_n;
        logic         load_n;
        logic         en_p;
        logic         en_t;
        logic [W-1:0] din;
        logic [W-1:0] exp_cnt;
        logic         exp_c;
    } vec_t;

    // Inputs applied for one edge, then count and carry expected after it.
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R3 clear
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'hFD, 8'hFD, 1'b0}, // R2 load, enables low
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFE, 1'b0}, // R4 count
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1}, // R5 carry at ones
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0}, // R5 en_t low kills carry
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1}, // R5 en_p low keeps carry
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R4 wrap
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h0F, 8'h0F, 1'b0}, // R2 load over count
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0}, // R6 slice carry
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h3F, 8'h00, 1'b0}, // R3 clear over load
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'hAB, 8'hAB, 1'b0}, // R2 load
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hAB, 1'b0}, // R1 hold, en_t low
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h7F, 8'h7F, 1'b0}, // R2 load
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h7F, 1'b0}, // R1 hold, en_p low
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h80, 1'b0}, // R6 slice carry
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'h0F, 8'h80, 1'b0}  // R1 data ignored
    };

    logic         clk = 1'b0;
    logic         clr_n;
    logic         clr_a_n;
    logic         load_n;
    logic         en_p;
    logic         en_t;
    logic [W-1:0] din;
    logic [W-1:0] count;
    logic [W-1:0] count_a;
    logic         carry_out;
    logic         carry_a;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cnt_chain #(.NUM_SLICES(2), .SLICE_W(4), .ASYNC_CLR(1'b0)) i_cnt_chain (
        .clk       (clk),
        .clr_n     (clr_n),
        .load_n    (load_n),
        .en_p      (en_p),
        .en_t      (en_t),
        .din       (din),
        .count     (count),
        .carry_out (carry_out)
    );

    cnt_chain #(.NUM_SLICES(2), .SLICE_W(4), .ASYNC_CLR(1'b1)) i_cnt_chain_async (
        .clk       (clk),
        .clr_n     (clr_a_n),
        .load_n    (load_n),
        .en_p      (en_p),
        .en_t      (en_t),
        .din       (din),
        .count     (count_a),
        .carry_out (carry_a)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int unsigned ref_cnt;
        clr_n   = 1'b0;
        clr_a_n = 1'b0;
        load_n  = 1'b1;
        en_p    = 1'b0;
        en_t    = 1'b0;
        din     = '0;

        // Reset state through clear (R3).
        repeat (2) @(posedge clk);
        #1;
        check("R3 reset count", 32'(count), 32'h0);
        check("R5 reset carry", 32'(carry_out), 32'h0);
        check("R3 reset async count", 32'(count_a), 32'h0);

        // Vector table.
        clr_a_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            clr_n  = VECS[i].clr_n;
            load_n = VECS[i].load_n;
            en_p   = VECS[i].en_p;
            en_t   = VECS[i].en_t;
            din    = VECS[i].din;
            @(posedge clk);
            #1;
            check($sformatf("R1/R2/R3/R4/R6 vector %0d count", i), 32'(count), 32'(VECS[i].exp_cnt));
            check($sformatf("R5 vector %0d carry", i), 32'(carry_out), 32'(VECS[i].exp_c));
        end

        // R3: clear timing on both builds.
        @(negedge clk);
        clr_n   = 1'b1;
        clr_a_n = 1'b1;
        load_n  = 1'b0;
        en_p    = 1'b0;
        en_t    = 1'b0;
        din     = 8'h5A;
        @(posedge clk);
        #1;
        check("R2 load sync build", 32'(count), 32'h5A);
        check("R2 load async build", 32'(count_a), 32'h5A);
        load_n  = 1'b1;
        clr_n   = 1'b0;
        clr_a_n = 1'b0;
        #0.5;
        check("R3 async clear immediate", 32'(count_a), 32'h0);
        check("R3 sync clear waits for edge", 32'(count), 32'h5A);
        @(posedge clk);
        #1;
        check("R3 sync clear at edge", 32'(count), 32'h0);
        clr_a_n = 1'b1;

        // R7: modulo-N count through decoded synchronous clear.
        ref_cnt = 0;
        for (int k = 0; k < 3 * MOD_N; k++) begin
            @(negedge clk);
            load_n = 1'b1;
            en_p   = 1'b1;
            en_t   = 1'b1;
            clr_n  = (count != 8'(MOD_N - 1));
            @(posedge clk);
            #1;
            ref_cnt = (ref_cnt == MOD_N - 1) ? 0 : ref_cnt + 1;
            check($sformatf("R7 modulo step %0d", k), 32'(count), 32'(ref_cnt));
        end

        @(negedge clk);
        en_p = 1'b0;
        en_t = 1'b0;
        clr_n = 1'b1;
        report();
    end

endmodule